// File: doc/BRIEF.md
# Scan code to ASCII key tracker

This block sits behind a keyboard serial receiver and turns the stream of set-2 scan-code bytes into one 8-bit level: the ASCII value of the key that is held right now, or 0x00 when nothing is held. Each byte arrives with a one-cycle valid strobe. The block remembers whether the previous byte was the break prefix, keeps one flag for each modifier key, and translates printable keys through a fixed table. Shift selects uppercase letters and the shifted digit symbols. Ctrl turns letters into control codes.

A host polls `key_o` whenever it likes, or watches `update_o`. That strobe rises for one cycle each time the held value actually changes. Modifier keys and untranslated codes never disturb the level. Extended-prefix codes, auto-repeat filtering and lock keys are not handled.

Top module: `keytrack_top`

## Requirements
- R1: After reset `key_o` is 0x00 and `update_o` is 0.
- R2: A byte with a table entry, with no break prefix pending and no modifier held, loads its unshifted ASCII value into `key_o` in the cycle after the byte. Examples: 0x1C gives 0x61, 0x16 gives 0x31 and 0x29 gives 0x20.
- R3: The byte 0xF0 marks the next byte as a key release. A release of any code other than a modifier code loads 0x00. The 0xF0 byte itself leaves `key_o` unchanged.
- R4: A pending release mark applies to exactly one following byte. The byte after that is treated as a press again.
- R5: `update_o` is high for one cycle, in the same cycle that `key_o` takes a new value. It stays low when a byte leaves the value unchanged, including a repeated press of the same key or a release while `key_o` is already 0x00.
- R6: While shift is held, letters map to uppercase (0x1C gives 0x41) and digit keys map to their shifted symbols (0x1E gives 0x40, 0x16 gives 0x21).
- R7: Left shift (0x12) and right shift (0x59) are tracked separately. Shift stays active while either of them is held.
- R8: A press or a release of 0x12, 0x59 or 0x14 never changes `key_o` and never raises `update_o`.
- R9: A press of a code with no table entry leaves `key_o` unchanged and raises no `update_o`.
- R10: With CTRL_MAP_EN set and ctrl (0x14) held, a letter maps to its uppercase ASCII value ANDed with 0x1F (0x1C gives 0x01, 0x32 gives 0x02), whatever the shift state. Keys that are not letters ignore ctrl.
- R11: Cycles with `byte_valid_i` low change neither `key_o` nor the release mark, whatever `code_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | One-cycle strobe marking a scan-code byte on `code_i` |
| code_i | input | 8 | Scan-code byte |
| key_o | output | 8 | ASCII value of the held key, 0x00 when none |
| update_o | output | 1 | One-cycle pulse when `key_o` changes |

## Verification
The bench builds the tracker with its default parameters. The prefix byte, both shift codes and the ctrl code keep their usual set-2 values, and CTRL_MAP_EN is 1. With these values the bench can reach the control-code path and its precedence over shift, as well as the case where releasing one shift key while the other is still held keeps uppercase output. It also drives scan codes while the valid strobe is low, and repeats presses, to show that the change strobe only follows real changes of the held value.

// File: rtl/keytrack_pkg.sv
package keytrack_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  hit;
    logic  alpha;
    code_t base;
    code_t shifted;
  } key_ent_t;

  function automatic code_t letter_of(code_t sc);
    code_t l;
    case (sc)
      8'h1C: l = 8'h61;  8'h32: l = 8'h62;  8'h21: l = 8'h63;  8'h23: l = 8'h64;
      8'h24: l = 8'h65;  8'h2B: l = 8'h66;  8'h34: l = 8'h67;  8'h33: l = 8'h68;
      8'h43: l = 8'h69;  8'h3B: l = 8'h6A;  8'h42: l = 8'h6B;  8'h4B: l = 8'h6C;
      8'h3A: l = 8'h6D;  8'h31: l = 8'h6E;  8'h44: l = 8'h6F;  8'h4D: l = 8'h70;
      8'h15: l = 8'h71;  8'h2D: l = 8'h72;  8'h1B: l = 8'h73;  8'h2C: l = 8'h74;
      8'h3C: l = 8'h75;  8'h2A: l = 8'h76;  8'h1D: l = 8'h77;  8'h22: l = 8'h78;
      8'h35: l = 8'h79;  8'h1A: l = 8'h7A;
      default: l = '0;
    endcase
    return l;
  endfunction

  function automatic key_ent_t key_lookup(code_t sc);
    key_ent_t e;
    code_t    l;
    e = '0;
    e.hit = 1'b1;
    l = letter_of(sc);
    if (l != '0) begin
      e.alpha   = 1'b1;
      e.base    = l;
      e.shifted = l - 8'h20;
    end else begin
      case (sc)
        8'h16: begin e.base = 8'h31; e.shifted = 8'h21; end
        8'h1E: begin e.base = 8'h32; e.shifted = 8'h40; end
        8'h26: begin e.base = 8'h33; e.shifted = 8'h23; end
        8'h25: begin e.base = 8'h34; e.shifted = 8'h24; end
        8'h2E: begin e.base = 8'h35; e.shifted = 8'h25; end
        8'h36: begin e.base = 8'h36; e.shifted = 8'h5E; end
        8'h3D: begin e.base = 8'h37; e.shifted = 8'h26; end
        8'h3E: begin e.base = 8'h38; e.shifted = 8'h2A; end
        8'h46: begin e.base = 8'h39; e.shifted = 8'h28; end
        8'h45: begin e.base = 8'h30; e.shifted = 8'h29; end
        8'h29: begin e.base = 8'h20; e.shifted = 8'h20; end
        8'h5A: begin e.base = 8'h0D; e.shifted = 8'h0D; end
        default: e.hit = 1'b0;
      endcase
    end
    return e;
  endfunction
endpackage

// File: rtl/keytrack_prefix.sv
module keytrack_prefix
  import keytrack_pkg::*;
#(
  parameter code_t REL_CODE = 8'hF0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  code_t code_i,
  output logic  rel_o
);
  logic rel_q;

  // each valid byte either re-arms or consumes the mark
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rel_q <= 1'b0;
    else if (valid_i) rel_q <= (code_i == REL_CODE);
  end

  assign rel_o = rel_q;

  // R4
  rel_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rel_q && code_i != REL_CODE) |=> !rel_q);
  // R11
  rel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rel_q));
endmodule

// File: rtl/keytrack_mods.sv
module keytrack_mods
  import keytrack_pkg::*;
#(
  parameter code_t LSHIFT_CODE = 8'h12,
  parameter code_t RSHIFT_CODE = 8'h59,
  parameter code_t CTRL_CODE   = 8'h14
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  code_t code_i,
  input  logic  rel_i,
  output logic  is_mod_o,
  output logic  shift_o,
  output logic  ctrl_o
);
  localparam int unsigned NUM_MOD = 3;
  localparam code_t MOD_CODE [NUM_MOD] = '{LSHIFT_CODE, RSHIFT_CODE, CTRL_CODE};

  logic [NUM_MOD-1:0] held_q;
  logic [NUM_MOD-1:0] match;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    assign match[i] = (code_i == MOD_CODE[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  held_q[i] <= 1'b0;
      else if (valid_i && match[i]) held_q[i] <= !rel_i;
    end
  end

  assign is_mod_o = |match;
  assign shift_o  = held_q[0] | held_q[1];
  assign ctrl_o   = held_q[2];

  // R7
  lshift_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rel_i && code_i == LSHIFT_CODE && held_q[1]) |=> shift_o);
  // R7
  rshift_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rel_i && code_i == RSHIFT_CODE) |=> shift_o);
endmodule

// File: rtl/keytrack_xlate.sv
module keytrack_xlate
  import keytrack_pkg::*;
#(
  parameter bit CTRL_MAP_EN = 1'b1
) (
  input  code_t code_i,
  input  logic  shift_i,
  input  logic  ctrl_i,
  output logic  hit_o,
  output code_t ascii_o
);
  key_ent_t ent;
  code_t    plain;

  assign ent   = key_lookup(code_i);
  assign hit_o = ent.hit;
  assign plain = shift_i ? ent.shifted : ent.base;

  if (CTRL_MAP_EN) begin : g_ctrl
    // control codes come from the uppercase letter
    assign ascii_o = (ctrl_i && ent.alpha) ? (ent.shifted & 8'h1F) : plain;
  end else begin : g_noctrl
    logic unused_ctrl;
    assign unused_ctrl = ctrl_i ^ ent.alpha;
    assign ascii_o     = plain;
  end

  // R2
  always_comb begin
    hit_zero_chk: assert (!hit_o || ascii_o != '0 || (ctrl_i && ent.alpha));
  end
endmodule

// File: rtl/keytrack_top.sv
module keytrack_top
  import keytrack_pkg::*;
#(
  parameter code_t REL_CODE    = 8'hF0,
  parameter code_t LSHIFT_CODE = 8'h12,
  parameter code_t RSHIFT_CODE = 8'h59,
  parameter code_t CTRL_CODE   = 8'h14,
  parameter bit    CTRL_MAP_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  code_i,
  output logic [7:0]  key_o,
  output logic        update_o
);
  logic  rel_pend, is_mod, shift, ctrl, hit, load;
  code_t ascii, nxt, key_q;
  logic  upd_q;

  keytrack_prefix #(.REL_CODE(REL_CODE)) u_prefix (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(byte_valid_i),
    .code_i(code_i), .rel_o(rel_pend)
  );

  keytrack_mods #(
    .LSHIFT_CODE(LSHIFT_CODE), .RSHIFT_CODE(RSHIFT_CODE), .CTRL_CODE(CTRL_CODE)
  ) u_mods (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(byte_valid_i), .code_i(code_i),
    .rel_i(rel_pend), .is_mod_o(is_mod), .shift_o(shift), .ctrl_o(ctrl)
  );

  keytrack_xlate #(.CTRL_MAP_EN(CTRL_MAP_EN)) u_xlate (
    .code_i(code_i), .shift_i(shift), .ctrl_i(ctrl),
    .hit_o(hit), .ascii_o(ascii)
  );

  always_comb begin
    load = 1'b0;
    nxt  = key_q;
    if (byte_valid_i && code_i != REL_CODE && !is_mod) begin
      if (rel_pend) begin
        load = 1'b1;
        nxt  = '0;
      end else if (hit) begin
        load = 1'b1;
        nxt  = ascii;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      upd_q <= 1'b0;
    end else begin
      key_q <= nxt;
      upd_q <= load && (nxt != key_q);
    end
  end

  assign key_o    = key_q;
  assign update_o = upd_q;

  // R5
  upd_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> key_o != $past(key_o));
  // R5
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o || $past(byte_valid_i));
  // R3
  release_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && rel_pend && !is_mod && code_i != REL_CODE) |=> key_o == '0);
  // R8
  mod_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && is_mod) |=> $stable(key_o) && !update_o);
  // R9
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !rel_pend && !is_mod && !hit) |=> $stable(key_o) && !update_o);
  // R11
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> $stable(key_o) && !update_o);
endmodule

// File: tb/keytrack_top_bench.sv
module keytrack_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] code = 8'h00;
  logic [7:0] key;
  logic       upd;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  keytrack_top u_keytrack_top (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid),
    .code_i(code), .key_o(key), .update_o(upd)
  );

  task automatic expect_out(string req, logic [7:0] k, logic u);
    n_chk++;
    if (key !== k || upd !== u) begin
      n_bad++;
      $display("FAIL %s: key=%h upd=%b, expected key=%h upd=%b", req, key, upd, k, u);
    end
  endtask

  // drive one byte for a cycle; outputs are registered, so sample at the next negedge
  task automatic send(logic [7:0] c);
    @(negedge clk);
    valid = 1'b1;
    code  = c;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic press(string req, logic [7:0] c, logic [7:0] k, logic u);
    send(c);
    expect_out(req, k, u);
  endtask

  task automatic release_key(string req, logic [7:0] c, logic [7:0] k_hold,
                             logic [7:0] k, logic u);
    send(8'hF0);
    expect_out({req, " prefix"}, k_hold, 1'b0);
    send(c);
    expect_out(req, k, u);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_out("R1", 8'h00, 1'b0);
  endtask

  task automatic t_plain();
    press("R2 a", 8'h1C, 8'h61, 1'b1);
    release_key("R3 a", 8'h1C, 8'h61, 8'h00, 1'b1);
    press("R2 1", 8'h16, 8'h31, 1'b1);
    release_key("R3 1", 8'h16, 8'h31, 8'h00, 1'b1);
    press("R2 space", 8'h29, 8'h20, 1'b1);
    release_key("R3 space", 8'h29, 8'h20, 8'h00, 1'b1);
  endtask

  task automatic t_prefix_once();
    release_key("R5 release at zero", 8'h1C, 8'h00, 8'h00, 1'b0);
    press("R4 mark consumed", 8'h1C, 8'h61, 1'b1);
    release_key("R4", 8'h1C, 8'h61, 8'h00, 1'b1);
  endtask

  task automatic t_shift();
    press("R8 shift press", 8'h12, 8'h00, 1'b0);
    press("R6 A", 8'h1C, 8'h41, 1'b1);
    press("R6 @", 8'h1E, 8'h40, 1'b1);
    release_key("R6", 8'h1E, 8'h40, 8'h00, 1'b1);
    release_key("R8 shift release", 8'h12, 8'h00, 8'h00, 1'b0);
    press("R6 back to lower", 8'h1C, 8'h61, 1'b1);
    release_key("R6", 8'h1C, 8'h61, 8'h00, 1'b1);
  endtask

  task automatic t_two_shift();
    press("R7", 8'h12, 8'h00, 1'b0);
    press("R7", 8'h59, 8'h00, 1'b0);
    release_key("R7", 8'h12, 8'h00, 8'h00, 1'b0);
    press("R7 right still held", 8'h1C, 8'h41, 1'b1);
    release_key("R7", 8'h1C, 8'h41, 8'h00, 1'b1);
    release_key("R7", 8'h59, 8'h00, 8'h00, 1'b0);
    press("R7 none held", 8'h1C, 8'h61, 1'b1);
    release_key("R7", 8'h1C, 8'h61, 8'h00, 1'b1);
  endtask

  task automatic t_mod_quiet();
    press("R2", 8'h1C, 8'h61, 1'b1);
    press("R8 ctrl press", 8'h14, 8'h61, 1'b0);
    release_key("R8 ctrl release", 8'h14, 8'h61, 8'h61, 1'b0);
    press("R8 rshift press", 8'h59, 8'h61, 1'b0);
    release_key("R8 rshift release", 8'h59, 8'h61, 8'h61, 1'b0);
    release_key("R3", 8'h1C, 8'h61, 8'h00, 1'b1);
  endtask

  task automatic t_unmapped();
    press("R2", 8'h1C, 8'h61, 1'b1);
    press("R9 unmapped", 8'h76, 8'h61, 1'b0);
    release_key("R3", 8'h1C, 8'h61, 8'h00, 1'b1);
  endtask

  task automatic t_ctrl();
    press("R8", 8'h14, 8'h00, 1'b0);
    press("R10 ctrl-a", 8'h1C, 8'h01, 1'b1);
    press("R8", 8'h12, 8'h01, 1'b0);
    press("R10 ctrl-shift-b", 8'h32, 8'h02, 1'b1);
    press("R10 digit ignores ctrl", 8'h16, 8'h21, 1'b1);
    release_key("R8", 8'h12, 8'h21, 8'h21, 1'b0);
    release_key("R8", 8'h14, 8'h21, 8'h21, 1'b0);
    release_key("R3", 8'h16, 8'h21, 8'h00, 1'b1);
  endtask

  task automatic t_dup();
    press("R5 first", 8'h1C, 8'h61, 1'b1);
    press("R5 repeat", 8'h1C, 8'h61, 1'b0);
    release_key("R5", 8'h1C, 8'h61, 8'h00, 1'b1);
  endtask

  task automatic t_idle();
    press("R2", 8'h1C, 8'h61, 1'b1);
    code = 8'hF0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_out("R11 idle", 8'h61, 1'b0);
    end
    code = 8'h32;
    @(negedge clk);
    expect_out("R11 idle", 8'h61, 1'b0);
    press("R11 no mark armed", 8'h32, 8'h62, 1'b1);
    release_key("R3", 8'h32, 8'h62, 8'h00, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d, expected < 20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_prefix_once();
    t_shift();
    t_two_shift();
    t_mod_quiet();
    t_unmapped();
    t_ctrl();
    t_dup();
    t_idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule